// File: doc/BRIEF.md
# Serial Flash Erase and Audio Record Sequencer

This block is the SPI master that prepares a page-organised serial flash for audio capture and then fills it with samples. On an erase request it walks every erase block of the array, one block-erase command per block, waiting on the flash's ready line between them. When the walk is done it marks the memory as fresh, so the next recording starts at the very first byte of the first page.

While the record input is held, each 10-bit converter sample is shifted down by a fixed floor and cut to 8 bits. The result is written into the flash's first SRAM buffer at the current byte position. When the buffer has received a full page of bytes, the block commits it to the next main-memory page with a program-without-erase command. A recording that stops part way through keeps its pointers, so a later recording appends at the next free byte. Once every page has been programmed, further samples are discarded and a memory-full flag is shown while recording is requested.

Samples that arrive while a command frame is still on the wire are kept in a single holding register. A sample that finds that register already occupied is lost, and a sticky overrun flag records the loss.

Top module: `flash_rec_seq`

## Requirements
- R1: The serial port works in SPI mode 3. SCK is high whenever CS is high. MOSI changes only together with a falling SCK edge, so it is stable at every rising edge. Bits go out MSB first. CS stays high for at least two half-periods of SCK (one SCK period) between frames.
- R2: A command frame starts (CS falls) only after a cycle in which the ready input was high.
- R3: An erase request produces one 32-bit frame per block, for blocks 0 to N_BLOCKS-1 in ascending order. The frame holds opcode 0x50 in bits 31..24, zeros in bits 23..22, the block number in bits 21..13 and zeros in bits 12..0. busy is high from the request until ready has returned high after the last block.
- R4: Each recorded byte equals the low 8 bits of (sample - 0x1D5), computed modulo 1024.
- R5: Each accepted sample produces one 40-bit frame. The frame holds opcode 0x84 in bits 39..32, zeros in bits 31..18, the byte position in bits 17..8 and the conditioned byte in bits 7..0.
- R6: After the byte at position PAGE_BYTES-1 has been written, a 32-bit frame follows. It holds opcode 0x88 in bits 31..24, zeros in bits 23..22, the page number in bits 21..10 and zeros in bits 9..0. The page number then increments, and the byte position restarts at 0.
- R7: A recording that resumes without an erase continues at the byte position and page after the last written byte.
- R8: After a completed erase, the next sample is written at byte position 0, and the next commit targets page 0.
- R9: After N_PAGES pages have been committed, samples produce no frame, and mem_full equals record_req. An erase clears this state.
- R10: If a sample arrives while one is already held and not being taken, it is dropped and overrun goes high and stays high until reset. The held sample is still written.
- R11: A sample presented while record_req is low produces no frame and leaves busy low.
- R12: After reset, cs_n, sck are high and busy, mem_full, overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_req | input | 1 | One-cycle request to erase the whole array |
| record_req | input | 1 | Held high while recording is wanted |
| smp_valid | input | 1 | A new converter sample is present this cycle |
| smp_raw | input | 10 | Raw converter sample |
| flash_ready | input | 1 | Flash ready (high) / busy (low) line |
| sck | output | 1 | SPI clock, idles high |
| mosi | output | 1 | SPI data to the flash |
| cs_n | output | 1 | Active-low flash select |
| busy | output | 1 | Sequencer is working or holds a sample |
| mem_full | output | 1 | All pages used while recording is requested |
| overrun | output | 1 | Sticky: a sample was lost |

## Verification
A frame is judged complete at the cycle CS rises. Each scenario therefore waits until busy has dropped, which happens only after CS has risen and the inter-frame gap has passed, and then compares the logged frames with values built from the field layout. busy rises on the cycle after an erase request or an accepted sample is registered, and the bench samples it at the next falling clock edge. mem_full follows record_req in the same cycle, so it is read one falling edge after record_req changes. overrun is read after the whole burst has drained, which also covers its stickiness.

// File: rtl/flash_rec_pkg.sv
package flash_rec_pkg;

  localparam int FRAME_W = 40;

  localparam logic [7:0] OP_BLK_ERASE = 8'h50;
  localparam logic [7:0] OP_BUF_WRITE = 8'h84;
  localparam logic [7:0] OP_BUF_PROG  = 8'h88;

  typedef enum logic [1:0] {
    CMD_ERASE = 2'd0,
    CMD_BUFWR = 2'd1,
    CMD_PROG  = 2'd2
  } cmd_e;

  // Shift the sample down by the floor and keep the low byte.
  function automatic logic [7:0] cond_sample(input logic [9:0] raw,
                                             input logic [9:0] floor_v);
    logic [9:0] diff;
    diff = raw - floor_v;
    return diff[7:0];
  endfunction

  // Frames are left-aligned in a 40-bit word; 32-bit frames pad the tail.
  function automatic logic [FRAME_W-1:0] erase_frame(input logic [8:0] blk);
    return {OP_BLK_ERASE, 2'b00, blk, 13'd0, 8'd0};
  endfunction

  function automatic logic [FRAME_W-1:0] bufwr_frame(input logic [9:0] pos,
                                                     input logic [7:0] data);
    return {OP_BUF_WRITE, 14'd0, pos, data};
  endfunction

  function automatic logic [FRAME_W-1:0] prog_frame(input logic [11:0] page);
    return {OP_BUF_PROG, 2'b00, page, 10'd0, 8'd0};
  endfunction

endpackage

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
  import flash_rec_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               five_bytes,
  output logic               sck,
  output logic               mosi,
  output logic               cs_n,
  output logic               active,
  output logic               done
);

  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int CNT_W   = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_TAIL, TX_GAP} tx_st_e;

  tx_st_e             st_q;
  logic [CNT_W-1:0]   div_q;
  logic [5:0]         bits_q;
  logic [FRAME_W-1:0] sh_q;
  logic               half_tick;

  assign half_tick = (div_q == HALF_LAST);
  assign active    = (st_q != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      div_q  <= '0;
      bits_q <= '0;
      sh_q   <= '0;
      sck    <= 1'b1;
      mosi   <= 1'b0;
      cs_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        TX_IDLE: begin
          if (start) begin
            cs_n   <= 1'b0;
            sh_q   <= frame;
            bits_q <= five_bytes ? 6'd40 : 6'd32;
            div_q  <= '0;
            st_q   <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (half_tick) begin
            div_q <= '0;
            if (sck) begin
              sck  <= 1'b0;
              mosi <= sh_q[FRAME_W-1];
              sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
            end else begin
              sck    <= 1'b1;
              bits_q <= bits_q - 6'd1;
              if (bits_q == 6'd1) st_q <= TX_TAIL;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        TX_TAIL: begin
          if (half_tick) begin
            cs_n  <= 1'b1;
            div_q <= '0;
            st_q  <= TX_GAP;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: begin
          if (div_q == GAP_LAST) begin
            div_q <= '0;
            done  <= 1'b1;
            st_q  <= TX_IDLE;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R1: clock idles high whenever the flash is deselected
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sck);

  // R1: data never moves on the sampling edge
  p_mosi_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

endmodule

// File: rtl/sample_hold.sv
module sample_hold #(
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [SMP_W-1:0] din,
  input  logic             pop,
  output logic             valid,
  output logic [SMP_W-1:0] dout,
  output logic             overrun
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      dout    <= '0;
      overrun <= 1'b0;
    end else begin
      if (pop && !capture) valid <= 1'b0;
      if (capture) begin
        if (!valid || pop) begin
          valid <= 1'b1;
          dout  <= din;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

  // R10: a lost sample stays reported
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> overrun);

  // R10: the consumer only takes a sample that is present
  p_pop_when_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> valid);

endmodule

// File: rtl/rec_seq_ctrl.sv
module rec_seq_ctrl
  import flash_rec_pkg::*;
#(
  parameter int          N_BLOCKS     = 512,
  parameter int          N_PAGES      = 4096,
  parameter int          PAGE_BYTES   = 528,
  parameter logic [9:0]  SAMPLE_FLOOR = 10'h1D5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase_req,
  input  logic               flash_ready,
  input  logic               hold_valid,
  input  logic [9:0]         hold_data,
  input  logic               tx_active,
  input  logic               tx_done,
  output logic               tx_start,
  output logic [FRAME_W-1:0] tx_frame,
  output logic               tx_five,
  output logic               pop,
  output logic               seq_busy,
  output logic               full
);

  localparam int BLK_W = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1;
  localparam int PG_W  = $clog2(N_PAGES + 1);
  localparam int POS_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(N_BLOCKS - 1);
  localparam logic [PG_W-1:0]  PG_LAST  = PG_W'(N_PAGES - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PAGE_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND, S_ERFIN} seq_st_e;

  seq_st_e          st_q;
  cmd_e             cmd_q;
  logic [BLK_W-1:0] blk_q;
  logic [PG_W-1:0]  page_q;
  logic [POS_W-1:0] pos_q;
  logic [7:0]       data_q;
  logic             fresh_q;
  logic             full_q;

  assign full     = full_q;
  assign seq_busy = (st_q != S_IDLE);
  assign pop      = (st_q == S_IDLE) && !erase_req && hold_valid;
  assign tx_start = (st_q == S_WAIT) && flash_ready && !tx_active;
  assign tx_five  = (cmd_q == CMD_BUFWR);

  always_comb begin
    case (cmd_q)
      CMD_ERASE: tx_frame = erase_frame(9'(blk_q));
      CMD_BUFWR: tx_frame = bufwr_frame(10'(pos_q), data_q);
      default:   tx_frame = prog_frame(12'(page_q));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cmd_q   <= CMD_BUFWR;
      blk_q   <= '0;
      page_q  <= '0;
      pos_q   <= '0;
      data_q  <= '0;
      fresh_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (erase_req) begin
            cmd_q   <= CMD_ERASE;
            blk_q   <= '0;
            full_q  <= 1'b0;
            fresh_q <= 1'b0;
            st_q    <= S_WAIT;
          end else if (hold_valid) begin
            if (fresh_q) begin
              pos_q   <= '0;
              page_q  <= '0;
              fresh_q <= 1'b0;
              data_q  <= cond_sample(hold_data, SAMPLE_FLOOR);
              cmd_q   <= CMD_BUFWR;
              st_q    <= S_WAIT;
            end else if (!full_q) begin
              data_q <= cond_sample(hold_data, SAMPLE_FLOOR);
              cmd_q  <= CMD_BUFWR;
              st_q   <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (tx_start) st_q <= S_SEND;
        end
        S_SEND: begin
          if (tx_done) begin
            case (cmd_q)
              CMD_ERASE: begin
                if (blk_q == BLK_LAST) begin
                  st_q <= S_ERFIN;
                end else begin
                  blk_q <= blk_q + 1'b1;
                  st_q  <= S_WAIT;
                end
              end
              CMD_BUFWR: begin
                if (pos_q == POS_LAST) begin
                  pos_q <= '0;
                  cmd_q <= CMD_PROG;
                  st_q  <= S_WAIT;
                end else begin
                  pos_q <= pos_q + 1'b1;
                  st_q  <= S_IDLE;
                end
              end
              default: begin
                page_q <= page_q + 1'b1;
                if (page_q == PG_LAST) full_q <= 1'b1;
                st_q <= S_IDLE;
              end
            endcase
          end
        end
        default: begin
          if (flash_ready) begin
            fresh_q <= 1'b1;
            st_q    <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R6: byte position never reaches the page size
  p_pos_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_LAST);

  // R9: page counter stops at the array size
  p_page_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_q <= PG_W'(N_PAGES));

  // R9: no buffer write is launched once memory is full
  p_no_write_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && cmd_q == CMD_BUFWR) |-> !full_q);

  // R3: a frame only finishes while this sequencer is sending
  p_done_in_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (st_q == S_SEND));

endmodule

// File: rtl/flash_rec_seq.sv
module flash_rec_seq
  import flash_rec_pkg::*;
#(
  parameter int         CLK_DIV      = 2,
  parameter int         N_BLOCKS     = 512,
  parameter int         N_PAGES      = 4096,
  parameter int         PAGE_BYTES   = 528,
  parameter logic [9:0] SAMPLE_FLOOR = 10'h1D5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       erase_req,
  input  logic       record_req,
  input  logic       smp_valid,
  input  logic [9:0] smp_raw,
  input  logic       flash_ready,
  output logic       sck,
  output logic       mosi,
  output logic       cs_n,
  output logic       busy,
  output logic       mem_full,
  output logic       overrun
);

  logic               hold_valid;
  logic [9:0]         hold_data;
  logic               pop;
  logic               tx_start;
  logic [FRAME_W-1:0] tx_frame;
  logic               tx_five;
  logic               tx_active;
  logic               tx_done;
  logic               seq_busy;
  logic               full;
  logic               smp_take;

  assign smp_take = smp_valid && record_req;

  sample_hold #(.SMP_W(10)) hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (smp_take),
    .din     (smp_raw),
    .pop     (pop),
    .valid   (hold_valid),
    .dout    (hold_data),
    .overrun (overrun)
  );

  rec_seq_ctrl #(
    .N_BLOCKS     (N_BLOCKS),
    .N_PAGES      (N_PAGES),
    .PAGE_BYTES   (PAGE_BYTES),
    .SAMPLE_FLOOR (SAMPLE_FLOOR)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase_req   (erase_req),
    .flash_ready (flash_ready),
    .hold_valid  (hold_valid),
    .hold_data   (hold_data),
    .tx_active   (tx_active),
    .tx_done     (tx_done),
    .tx_start    (tx_start),
    .tx_frame    (tx_frame),
    .tx_five     (tx_five),
    .pop         (pop),
    .seq_busy    (seq_busy),
    .full        (full)
  );

  spi_frame_tx #(.CLK_DIV(CLK_DIV)) tx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (tx_start),
    .frame      (tx_frame),
    .five_bytes (tx_five),
    .sck        (sck),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .active     (tx_active),
    .done       (tx_done)
  );

  assign busy     = seq_busy || hold_valid;
  assign mem_full = full && record_req;

  // R2: the flash is only selected after it reported ready
  p_ready_before_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(flash_ready));

  // R1: a select always starts from an idle-high clock
  p_cs_fall_sck_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sck);

endmodule

// File: tb/flash_rec_seq_tb.sv
module flash_rec_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int NB         = 3;
  localparam int NP         = 2;
  localparam int PB         = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       erase_req = 1'b0;
  logic       record_req = 1'b0;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_raw = '0;
  logic       flash_ready = 1'b1;
  logic       sck, mosi, cs_n, busy, mem_full, overrun;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rec_seq #(
    .CLK_DIV(DIV), .N_BLOCKS(NB), .N_PAGES(NP), .PAGE_BYTES(PB),
    .SAMPLE_FLOOR(10'h1D5)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .record_req(record_req),
    .smp_valid(smp_valid), .smp_raw(smp_raw), .flash_ready(flash_ready),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .mem_full(mem_full),
    .overrun(overrun)
  );

  // ---- flash model and frame logger (falling edge) ----
  logic [39:0] fr_val [0:63];
  int          fr_bits[0:63];
  int          fr_n = 0;
  logic [39:0] cap = '0;
  int          nbits = 0;
  logic        prev_cs = 1'b1, prev_sck = 1'b1;
  int          gap_cnt = 100;
  int          rdy_cnt = 0;
  int          r1_viol = 0;
  int          r2_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && sck && !prev_sck) begin
        cap = {cap[38:0], mosi};
        nbits++;
      end
      if (prev_cs && !cs_n) begin
        if (gap_cnt < 2*DIV) r1_viol++;
        if (!flash_ready) r2_viol++;
        cap = '0;
        nbits = 0;
      end
      if (!prev_cs && cs_n) begin
        if (fr_n < 64) begin
          fr_val[fr_n]  = cap << (40 - nbits);
          fr_bits[fr_n] = nbits;
          if (fr_val[fr_n][39:32] == 8'h50 || fr_val[fr_n][39:32] == 8'h88)
            rdy_cnt = 15;
          fr_n++;
        end
        gap_cnt = 0;
      end
      if (cs_n) gap_cnt++;
      if (cs_n && !sck) r1_viol++;
      if (rdy_cnt > 0) rdy_cnt--;
      flash_ready = (rdy_cnt == 0);
      prev_cs  = cs_n;
      prev_sck = sck;
    end
  end

  // ---- helpers ----
  task automatic check(input bit ok, input string req,
                       input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] x_erase(input int b);
    return (40'h50 << 32) | (40'(b) << 21);
  endfunction
  function automatic logic [39:0] x_write(input int pos, input int raw);
    int d;
    d = (raw + 1024 - 'h1D5) % 256;
    return (40'h84 << 32) | (40'(pos) << 8) | 40'(d);
  endfunction
  function automatic logic [39:0] x_prog(input int pg);
    return (40'h88 << 32) | (40'(pg) << 18);
  endfunction

  task automatic expect_frame(input int idx, input logic [39:0] exp,
                              input int bits, input string req);
    if (idx >= fr_n) begin
      check(1'b0, req, 40'(fr_n), 40'(idx + 1));
    end else begin
      check(fr_val[idx] == exp && fr_bits[idx] == bits, req, fr_val[idx], exp);
    end
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_sample(input int v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_raw   = 10'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_erase();
    @(negedge clk);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R3 busy during erase", 40'(busy), 40'd1);
    wait_idle();
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check(cs_n == 1'b1 && sck == 1'b1, "R12 cs_n/sck idle", {38'd0, cs_n, sck}, 40'd3);
    check(busy == 0 && mem_full == 0 && overrun == 0, "R12 flags low",
          {37'd0, busy, mem_full, overrun}, 40'd0);
  endtask

  task automatic t_erase();
    int base;
    base = fr_n;
    do_erase();
    check(fr_n - base == NB, "R3 erase frame count", 40'(fr_n - base), 40'(NB));
    for (int b = 0; b < NB; b++) expect_frame(base + b, x_erase(b), 32, "R3 erase frame");
  endtask

  task automatic t_record_page();
    int base;
    int vals[5] = '{'h1D5, 'h3FF, 'h000, 'h2D4, 'h1D6};
    base = fr_n;
    record_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      send_sample(vals[i]);
      wait_idle();
    end
    check(fr_n - base == 6, "R6 frames for one page plus one", 40'(fr_n - base), 40'd6);
    for (int i = 0; i < 4; i++) expect_frame(base + i, x_write(i, vals[i]), 40, "R4 R5 R8 buffer write");
    expect_frame(base + 4, x_prog(0), 32, "R6 commit page 0");
    expect_frame(base + 5, x_write(0, vals[4]), 40, "R6 byte position restarts");
  endtask

  task automatic t_ignore();
    int base;
    base = fr_n;
    record_req = 1'b0;
    send_sample('h250);
    @(negedge clk);
    check(busy == 1'b0, "R11 busy stays low", 40'(busy), 40'd0);
    repeat (60) @(negedge clk);
    check(fr_n == base, "R11 no frame when not recording", 40'(fr_n - base), 40'd0);
  endtask

  task automatic t_append();
    int base;
    base = fr_n;
    record_req = 1'b1;
    send_sample('h200);
    wait_idle();
    expect_frame(base, x_write(1, 'h200), 40, "R7 append at next byte");
  endtask

  task automatic t_full();
    int base;
    base = fr_n;
    send_sample('h300);
    wait_idle();
    send_sample('h301);
    wait_idle();
    expect_frame(base + 2, x_prog(1), 32, "R9 last page commit");
    check(mem_full == 1'b1, "R9 mem_full while recording", 40'(mem_full), 40'd1);
    base = fr_n;
    send_sample('h123);
    repeat (80) @(negedge clk);
    check(fr_n == base, "R9 sample dropped when full", 40'(fr_n - base), 40'd0);
    record_req = 1'b0;
    @(negedge clk);
    check(mem_full == 1'b0, "R9 mem_full follows record_req", 40'(mem_full), 40'd0);
  endtask

  task automatic t_erase_restart();
    int base;
    do_erase();
    check(mem_full == 1'b0, "R9 erase clears full", 40'(mem_full), 40'd0);
    base = fr_n;
    record_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      send_sample('h1E0 + i);
      wait_idle();
    end
    expect_frame(base, x_write(0, 'h1E0), 40, "R8 first byte after erase");
    expect_frame(base + 4, x_prog(0), 32, "R8 first commit after erase");
  endtask

  task automatic t_overrun();
    int base;
    check(overrun == 1'b0, "R10 overrun clear before burst", 40'(overrun), 40'd0);
    base = fr_n;
    @(negedge clk);
    smp_valid = 1'b1; smp_raw = 10'h210;
    @(negedge clk);
    smp_raw = 10'h220;
    @(negedge clk);
    smp_raw = 10'h230;
    @(negedge clk);
    smp_valid = 1'b0;
    wait_idle();
    check(fr_n - base == 2, "R10 two samples kept", 40'(fr_n - base), 40'd2);
    expect_frame(base, x_write(0, 'h210), 40, "R10 first sample");
    expect_frame(base + 1, x_write(1, 'h220), 40, "R10 held sample");
    repeat (20) @(negedge clk);
    check(overrun == 1'b1, "R10 overrun sticky", 40'(overrun), 40'd1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", 40'(cyc), 40'd0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erase();
    t_record_page();
    t_ignore();
    t_append();
    t_full();
    t_erase_restart();
    t_overrun();
    check(r1_viol == 0, "R1 mode 3 idle level and CS gap", 40'(r1_viol), 40'd0);
    check(r2_viol == 0, "R2 start only when ready", 40'(r2_viol), 40'd0);
    finish_run();
  end

endmodule